// File: doc/BRIEF.md
# Flash command sequence interpreter

This block models the device side of a byte-wide flash array split into eight equal sectors. It watches a clock-sampled bus (chip select, write strobe, output enable, address and data). It recognises multi-cycle unlock sequences written to two fixed addresses, and from them it runs byte programming, erasure of one or several queued sectors, or erasure of the whole chip. Each of these operations lasts a fixed number of clock cycles, set by a parameter.

While an operation runs there is no ready pin. Instead, any read returns the complement of bit 7 of the data being written, and the lower seven bits read as zero. When the operation finishes, reads show the array contents again. A per-sector lock mask makes program and erase skip sectors silently. A supply-good input that is low makes the block ignore writes. The array is held in registers. Its depth is reduced by a parameter: within each sector only the low `OFS_W` address bits are stored.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset every stored byte reads FFh and the interpreter is in read mode.
- R2: `dout_en` is 1 exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1. `dout` is 00h whenever `dout_en` is 0. When the block is idle, `dout` is the byte at sector `addr[18:16]`, offset `addr[OFS_W-1:0]`.
- R3: The write cycles AAh to 5555h, 55h to 2AAAh and A0h to 5555h, followed by a data write, program the target byte to old AND data. Unlock addresses are matched on `addr[14:0]`. A write cycle is a clock edge with `ce_n`=0 and `we_n`=0.
- R4: While an operation is busy, a read at any address returns bit 7 equal to the inverse of the written bit 7 (0 for erase) and bits 6..0 equal to 0.
- R5: Busy starts at the edge of the data write (program) or the final 10h write (chip erase) and lasts exactly `PROG_CYC` or `ERASE_CYC` cycles. A sector erase is busy for `ERASE_CYC` cycles once its queue window closes.
- R6: The write cycles AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h set every byte of every unlocked sector to FFh.
- R7: The same five-cycle prefix followed by 30h at any address of a sector queues that sector. Each further 30h write restarts a window of `QWIN_CYC` cycles. When the window expires, all queued sectors are erased to FFh. During the window, reads still show the array.
- R8: A write that does not match the expected address and data returns the interpreter to read mode without changing the array. This includes any write other than 30h during the queue window.
- R9: Write cycles made while an operation is busy are ignored.
- R10: Write cycles made while `vcc_ok`=0 are ignored, and a sequence already in progress is kept.
- R11: A program aimed at a sector whose `sect_lock` bit is set changes nothing and never goes busy. Sector and chip erase leave locked sectors unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | BUS_AW | Byte address; the top 3 bits select the sector |
| din | input | 8 | Write data |
| vcc_ok | input | 1 | Supply good; 0 locks out writes |
| sect_lock | input | 8 | Per-sector protection mask |
| dout | output | 8 | Read data or polling status |
| dout_en | output | 1 | Read data valid / drive enable |

## Verification
The bench builds the block with `OFS_W`=4, so the array holds 128 bytes. This makes it practical to program every byte twice, check the AND rule everywhere, and read back the whole array after each erase. `PROG_CYC`=8, `ERASE_CYC`=12 and `QWIN_CYC`=5 keep each timed operation short. As a result, the last busy cycle, the first idle cycle and the edges of the queue window can each be sampled exactly, and sequences can be fired into a running operation.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int UNL_W = 15;
  localparam logic [UNL_W-1:0] UNL_ADDR_A = 15'h5555;
  localparam logic [UNL_W-1:0] UNL_ADDR_B = 15'h2AAA;

  localparam logic [7:0] CMD_UNL1  = 8'hAA;
  localparam logic [7:0] CMD_UNL2  = 8'h55;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_ERASE = 8'h80;
  localparam logic [7:0] CMD_CHIP  = 8'h10;
  localparam logic [7:0] CMD_SECT  = 8'h30;

  typedef enum logic [3:0] {
    S_READ, S_UNL1, S_UNL2, S_PGM, S_ERA1, S_ERA2, S_ERA3, S_QUEUE, S_BUSY
  } seq_state_t;
endpackage

// File: rtl/flash_down_counter.sv
module flash_down_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array #(
  parameter int SECT_W = 3,
  parameter int OFS_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SECT_W+OFS_W-1:0] rd_idx,
  output logic [7:0]              rd_data,
  input  logic                    prog_en,
  input  logic [SECT_W+OFS_W-1:0] prog_idx,
  input  logic [7:0]              prog_data,
  input  logic                    erase_en,
  input  logic [(1<<SECT_W)-1:0]  erase_mask
);
  localparam int IDX_W = SECT_W + OFS_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [7:0]       mem_q [DEPTH];
  logic [DEPTH-1:0] row_en;

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    localparam int SECT_OF_ROW = i >> OFS_W;
    assign row_en[i] = (prog_en && (prog_idx == IDX_W'(i))) ||
                       (erase_en && erase_mask[SECT_OF_ROW]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (row_en[i]) mem_q[i] <= erase_en ? 8'hFF : (mem_q[i] & prog_data);
    end
  end

  assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/flash_seq_decode.sv
module flash_seq_decode
  import flash_cmd_pkg::*;
#(
  parameter int BUS_AW    = 19,
  parameter int SECT_W    = 3,
  parameter int OFS_W     = 4,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 64,
  parameter int QWIN_CYC  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic [BUS_AW-1:0]       addr,
  input  logic [7:0]              din,
  input  logic [(1<<SECT_W)-1:0]  sect_lock,
  output seq_state_t              state,
  output logic                    busy,
  output logic                    poll7,
  output logic                    tmr_zero,
  output logic                    commit_prog,
  output logic                    commit_erase,
  output logic [SECT_W+OFS_W-1:0] prog_idx,
  output logic [7:0]              prog_data,
  output logic [(1<<SECT_W)-1:0]  erase_mask
);
  localparam int NSECT = 1 << SECT_W;
  localparam int IDX_W = SECT_W + OFS_W;
  localparam int MAX_PE = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int MAX_C  = (MAX_PE > QWIN_CYC) ? MAX_PE : QWIN_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  seq_state_t       state_q, state_d;
  logic [NSECT-1:0] mask_q, mask_d, sect_oh, free_sect;
  logic [IDX_W-1:0] pidx_q;
  logic [7:0]       pdata_q;
  logic             poll7_q, poll7_d, isprog_q, isprog_d, cap;
  logic             tmr_load, at_a, at_b;
  logic [CNT_W-1:0] tmr_val;
  logic [SECT_W-1:0] sect;
  logic             unused_addr;

  assign sect        = addr[BUS_AW-1 -: SECT_W];
  assign sect_oh     = NSECT'(1) << sect;
  assign free_sect   = ~sect_lock;
  assign at_a        = (addr[UNL_W-1:0] == UNL_ADDR_A);
  assign at_b        = (addr[UNL_W-1:0] == UNL_ADDR_B);
  assign unused_addr = ^addr;

  flash_down_counter #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  always_comb begin
    state_d = state_q;  mask_d = mask_q;  poll7_d = poll7_q;  isprog_d = isprog_q;
    tmr_load = 1'b0;  tmr_val = '0;  cap = 1'b0;
    commit_prog = 1'b0;  commit_erase = 1'b0;
    unique case (state_q)
      S_READ: if (wr && at_a && din == CMD_UNL1) state_d = S_UNL1;
      S_UNL1: if (wr) state_d = (at_b && din == CMD_UNL2) ? S_UNL2 : S_READ;
      S_UNL2: if (wr) begin
        if (at_a && din == CMD_PROG)       state_d = S_PGM;
        else if (at_a && din == CMD_ERASE) state_d = S_ERA1;
        else                               state_d = S_READ;
      end
      S_PGM: if (wr) begin
        cap = 1'b1;
        if (sect_lock[sect]) state_d = S_READ;
        else begin
          state_d = S_BUSY;  isprog_d = 1'b1;  poll7_d = ~din[7];
          tmr_load = 1'b1;   tmr_val = CNT_W'(PROG_CYC - 1);
        end
      end
      S_ERA1: if (wr) state_d = (at_a && din == CMD_UNL1) ? S_ERA2 : S_READ;
      S_ERA2: if (wr) state_d = (at_b && din == CMD_UNL2) ? S_ERA3 : S_READ;
      S_ERA3: if (wr) begin
        if (at_a && din == CMD_CHIP) begin
          mask_d = free_sect;
          if (free_sect != '0) begin
            state_d = S_BUSY;  isprog_d = 1'b0;  poll7_d = 1'b0;
            tmr_load = 1'b1;   tmr_val = CNT_W'(ERASE_CYC - 1);
          end else state_d = S_READ;
        end else if (din == CMD_SECT) begin
          mask_d = sect_oh & free_sect;  state_d = S_QUEUE;
          tmr_load = 1'b1;  tmr_val = CNT_W'(QWIN_CYC - 1);
        end else state_d = S_READ;
      end
      S_QUEUE: begin
        if (wr) begin
          if (din == CMD_SECT) begin
            mask_d = mask_q | (sect_oh & free_sect);
            tmr_load = 1'b1;  tmr_val = CNT_W'(QWIN_CYC - 1);
          end else begin
            mask_d = '0;  state_d = S_READ;
          end
        end else if (tmr_zero) begin
          if (mask_q != '0) begin
            state_d = S_BUSY;  isprog_d = 1'b0;  poll7_d = 1'b0;
            tmr_load = 1'b1;   tmr_val = CNT_W'(ERASE_CYC - 1);
          end else state_d = S_READ;
        end
      end
      S_BUSY: if (tmr_zero) begin
        state_d = S_READ;
        commit_prog  = isprog_q;
        commit_erase = ~isprog_q;
      end
      default: state_d = S_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_READ;  mask_q <= '0;  poll7_q <= 1'b0;  isprog_q <= 1'b0;
    end else begin
      state_q <= state_d;  mask_q <= mask_d;  poll7_q <= poll7_d;  isprog_q <= isprog_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pidx_q <= '0;  pdata_q <= 8'hFF;
    end else if (cap) begin
      pidx_q <= {sect, addr[OFS_W-1:0]};  pdata_q <= din;
    end
  end

  assign state      = state_q;
  assign busy       = (state_q == S_BUSY);
  assign poll7      = poll7_q;
  assign prog_idx   = pidx_q;
  assign prog_data  = pdata_q;
  assign erase_mask = mask_q;
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import flash_cmd_pkg::*;
#(
  parameter int BUS_AW    = 19,
  parameter int OFS_W     = 4,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 64,
  parameter int QWIN_CYC  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [BUS_AW-1:0] addr,
  input  logic [7:0]        din,
  input  logic              vcc_ok,
  input  logic [7:0]        sect_lock,
  output logic [7:0]        dout,
  output logic              dout_en
);
  localparam int SECT_W = 3;
  localparam int IDX_W  = SECT_W + OFS_W;
  localparam int NSECT  = 1 << SECT_W;

  seq_state_t       seq_state;
  logic             bus_wr, op_busy, poll7, tmr_zero, commit_prog, commit_erase;
  logic [IDX_W-1:0] prog_idx, rd_idx;
  logic [7:0]       prog_data, rd_byte;
  logic [NSECT-1:0] erase_mask;

  assign bus_wr = !ce_n && !we_n && vcc_ok;
  assign rd_idx = {addr[BUS_AW-1 -: SECT_W], addr[OFS_W-1:0]};

  flash_seq_decode #(
    .BUS_AW(BUS_AW), .SECT_W(SECT_W), .OFS_W(OFS_W),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .QWIN_CYC(QWIN_CYC)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(addr), .din(din),
    .sect_lock(sect_lock), .state(seq_state), .busy(op_busy), .poll7(poll7),
    .tmr_zero(tmr_zero), .commit_prog(commit_prog), .commit_erase(commit_erase),
    .prog_idx(prog_idx), .prog_data(prog_data), .erase_mask(erase_mask)
  );

  flash_byte_array #(.SECT_W(SECT_W), .OFS_W(OFS_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_byte),
    .prog_en(commit_prog), .prog_idx(prog_idx), .prog_data(prog_data),
    .erase_en(commit_erase), .erase_mask(erase_mask)
  );

  assign dout_en = !ce_n && !oe_n && we_n;

  always_comb begin
    if (!dout_en)     dout = 8'h00;
    else if (op_busy) dout = {poll7, 7'b0};
    else              dout = rd_byte;
  end
endmodule

// File: rtl/flash_cmd_engine_chk.sv
module flash_cmd_engine_chk
  import flash_cmd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       vcc_ok,
  input logic [7:0] din,
  input logic [7:0] dout,
  input logic       dout_en,
  input logic       op_busy,
  input logic       tmr_zero,
  input logic       bus_wr,
  input seq_state_t seq_state
);
  // R2
  idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> dout == 8'h00);

  // R4
  poll_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy && dout_en) |-> dout[6:0] == 7'b0);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy && !tmr_zero) |=> op_busy);

  // R10
  lockout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vcc_ok && seq_state != S_BUSY && seq_state != S_QUEUE) |=> $stable(seq_state));

  // R8
  queue_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == S_QUEUE && bus_wr && din != CMD_SECT) |=> seq_state == S_READ);

  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_busy) |-> ($past(bus_wr) || $past(seq_state) == S_QUEUE));
endmodule

bind flash_cmd_engine flash_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .din(din), .dout(dout),
  .dout_en(dout_en), .op_busy(op_busy), .tmr_zero(tmr_zero),
  .bus_wr(bus_wr), .seq_state(seq_state)
);

// File: tb/flash_cmd_engine_bench.sv
module flash_cmd_engine_bench;
  localparam int P = 8, E = 12, Q = 5;

  logic        clk, rst_n, ce_n, we_n, oe_n, vcc_ok;
  logic [18:0] addr;
  logic [7:0]  din, sect_lock, dout, q;
  logic        dout_en;
  logic [7:0]  exp_mem [128];
  int          checks, failures;

  flash_cmd_engine #(.BUS_AW(19), .OFS_W(4), .PROG_CYC(P), .ERASE_CYC(E), .QWIN_CYC(Q))
  u_flash_cmd_engine (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
    .din(din), .vcc_ok(vcc_ok), .sect_lock(sect_lock), .dout(dout), .dout_en(dout_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [18:0] loc(input int s, input int o);
    return {3'(s), 12'h000, 4'(o)};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; din = d;
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic rd(input logic [18:0] a);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
    #1 q = dout;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock();
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55);
  endtask

  task automatic prog_seq(input logic [18:0] a, input logic [7:0] d);
    unlock(); wr(19'h05555, 8'hA0); wr(a, d);
  endtask

  task automatic erase_prefix();
    unlock(); wr(19'h05555, 8'h80); unlock();
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 128; i++) begin
      rd(loc(i / 16, i % 16));
      check(req, q, exp_mem[i]);
    end
  endtask

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    addr = '0; din = '0; vcc_ok = 1'b1; sect_lock = 8'h00; q = '0;
    for (int i = 0; i < 128; i++) exp_mem[i] = 8'hFF;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    // R2: deselected bus
    #1 check("R2 dout_en idle", {7'b0, dout_en}, 8'h00);
    check("R2 dout idle", dout, 8'h00);
    // R1: blank array after reset
    sweep("R1 reset contents");
    // R2: output enable high, and during a write cycle
    ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; #1;
    check("R2 oe_n high", {7'b0, dout_en}, 8'h00);
    wait_cyc(1);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = '0; din = 8'h00; #1;
    check("R2 during write", {7'b0, dout_en}, 8'h00);
    wait_cyc(1); ce_n = 1'b1; we_n = 1'b1;

    // R3/R4/R5: program every byte, probe polling and busy length
    for (int i = 0; i < 128; i++) begin
      logic [7:0] f;
      f = 8'((i * 73 + 29) & 255);
      prog_seq(loc(i / 16, i % 16), f);
      rd(loc(i / 16, i % 16));
      check("R4 poll after program", q, {~f[7], 7'b0});
      wait_cyc(P - 1);
      rd(loc(((i + 1) % 128) / 16, (i + 1) % 16));
      check("R5 last busy cycle", q, {~f[7], 7'b0});
      wait_cyc(1);
      exp_mem[i] = exp_mem[i] & f;
      rd(loc(i / 16, i % 16));
      check("R3 program result", q, exp_mem[i]);
    end
    sweep("R3 first pass");
    for (int i = 0; i < 128; i++) begin
      logic [7:0] g;
      g = 8'((i * 151) & 255) ^ 8'h5A;
      prog_seq(loc(i / 16, i % 16), g);
      wait_cyc(P);
      exp_mem[i] = exp_mem[i] & g;
    end
    sweep("R3 AND rule");

    // R8: wrong unlock address, then wrong command
    wr(19'h05555, 8'hAA); wr(19'h01234, 8'h55); wr(19'h05555, 8'hA0); wr(loc(2, 3), 8'h00);
    rd(loc(2, 3)); check("R8 bad unlock addr", q, exp_mem[35]);
    wait_cyc(P + 2); rd(loc(2, 3)); check("R8 bad unlock addr later", q, exp_mem[35]);
    unlock(); wr(19'h05555, 8'h90); wr(loc(2, 3), 8'h00);
    wait_cyc(P + 2); rd(loc(2, 3)); check("R8 bad command", q, exp_mem[35]);

    // R10: lockout ignores writes and keeps a partial sequence
    vcc_ok = 1'b0;
    prog_seq(loc(2, 3), 8'h00);
    rd(loc(2, 3)); check("R10 no busy in lockout", q, exp_mem[35]);
    wait_cyc(P + 2); rd(loc(2, 3)); check("R10 unchanged", q, exp_mem[35]);
    vcc_ok = 1'b1; unlock(); vcc_ok = 1'b0; wr(19'h00000, 8'h12); vcc_ok = 1'b1;
    wr(19'h05555, 8'hA0); wr(loc(2, 3), 8'h0F);
    rd(loc(2, 3)); check("R10 sequence kept", q, 8'h80);
    wait_cyc(P); exp_mem[35] = exp_mem[35] & 8'h0F;
    rd(loc(2, 3)); check("R10 resumed program", q, exp_mem[35]);

    // R11: program into locked sector 2
    sect_lock = 8'h04;
    prog_seq(loc(2, 4), 8'h00);
    rd(loc(2, 4)); check("R11 locked program not busy", q, exp_mem[36]);
    wait_cyc(P + 2); rd(loc(2, 4)); check("R11 locked program unchanged", q, exp_mem[36]);

    // R7: queue sectors 1, 2 (locked) and 5
    erase_prefix();
    wr(loc(1, 0), 8'h30); wr(loc(2, 0), 8'h30); wr(loc(5, 9), 8'h30);
    wait_cyc(Q - 1); rd(loc(1, 0)); check("R7 window shows array", q, exp_mem[16]);
    wait_cyc(1); rd(loc(7, 7)); check("R7 erase busy poll", q, 8'h00);
    wait_cyc(E - 1); rd(loc(1, 0)); check("R5 erase last busy", q, 8'h00);
    wait_cyc(1);
    for (int o = 0; o < 16; o++) begin exp_mem[16 + o] = 8'hFF; exp_mem[80 + o] = 8'hFF; end
    rd(loc(1, 0)); check("R7 erased", q, 8'hFF);
    sweep("R11 sector erase skips lock");

    // R8: non-30h write cancels the queue window
    sect_lock = 8'h00;
    erase_prefix(); wr(loc(6, 0), 8'h30); wr(loc(6, 0), 8'h55);
    wait_cyc(Q + E + 2);
    sweep("R8 queue cancelled");

    // R6: chip erase with sector 3 locked
    sect_lock = 8'h08;
    erase_prefix(); wr(19'h05555, 8'h10);
    rd(loc(0, 0)); check("R6 chip erase busy", q, 8'h00);
    wait_cyc(E - 1); rd(loc(0, 0)); check("R5 chip erase last busy", q, 8'h00);
    wait_cyc(1);
    for (int i = 0; i < 128; i++) if (i / 16 != 3) exp_mem[i] = 8'hFF;
    sweep("R6 chip erase result");

    // R9: a full sequence fired during busy is ignored
    sect_lock = 8'h00;
    prog_seq(loc(0, 1), 8'h0F);
    prog_seq(loc(4, 2), 8'h00);
    wait_cyc(P);
    exp_mem[1] = 8'h0F;
    rd(loc(0, 1)); check("R9 first program", q, 8'h0F);
    rd(loc(4, 2)); check("R9 ignored program", q, 8'hFF);
    sweep("R9 final contents");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule